// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the slave end of a two-wire serial memory link. It oversamples the clock and data lines of the bus in a fast system clock. From those samples it finds the framing conditions: data falling while the clock is high opens a transfer, and data rising while the clock is high closes one. Between those conditions it shifts bytes in and out. It pulls the data line low through an open-drain enable and never drives it high.

After an opening condition, the first byte carries a device selector. The block answers only when the selector holds the type code 1010 followed by its three strap pins. The selector's last bit picks between storing and fetching.

- **Storing:** the next byte loads a word pointer. Each later byte is handed, with its target location, to a separate page-write unit.
- **Fetching:** bytes are streamed from a 256-entry memory port starting at the pointer. Streaming continues for as long as the master acknowledges.

The pointer steps after every byte moved and wraps at the top. While the page-write unit reports that it is busy, the block stays silent.

Top module: `tw_eeprom_slave`

## Requirements
- R1: Until an opening condition (data falls while clock is high) has been seen, the block ignores all bus traffic and leaves the data line released (`sda_drive_low` = 0).
- R2: The selector byte is received MSB first as {type[3:0], strap[2:0], dir}. When type = 4'b1010 and strap equals `strap_addr`, the block pulls the line low throughout the ninth clock. On any mismatch it leaves the line released and ignores traffic until the next opening condition.
- R3: While `wr_busy` is 1 at the end of the selector byte, the block gives no acknowledge, even for a matching selector.
- R4: With dir = 0, the byte after the selector is loaded into the word pointer and acknowledged. Each following byte is acknowledged and presented for exactly one clock on `wb_valid`, with `wb_addr` holding the pointer value and `wb_data` holding the byte.
- R5: The word pointer (`mem_addr`) advances by one after every byte written or fetched, and goes from 255 to 0.
- R6: With dir = 1, the block sends memory bytes MSB first, starting at the pointer, and releases the line during the ninth clock. If the ninth bit is low it sends the next byte. If that bit is high, it keeps the line released until the next condition.
- R7: A closing condition (data rises while clock is high) returns the block to idle. If at least one data byte was accepted in a storing transfer, that condition also gives a one-clock pulse on `wb_commit`.
- R8: An opening condition at any point, including inside a byte, aborts the transfer and restarts selector reception.
- R9: The block changes `sda_drive_low` only while the synchronized clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin (wired level) |
| sda_drive_low | output | 1 | 1 = pull the data line low, 0 = release it |
| strap_addr | input | 3 | Pin-strapped low bits of the device selector |
| wr_busy | input | 1 | Page-write unit is busy with an internal cycle |
| mem_addr | output | 8 | Word pointer, used as the memory read address |
| mem_rdata | input | 8 | Memory read data for `mem_addr`, combinational |
| wb_valid | output | 1 | One-clock strobe: a write byte is offered |
| wb_addr | output | 8 | Location of the offered write byte |
| wb_data | output | 8 | Offered write byte |
| wb_commit | output | 1 | One-clock pulse when a storing transfer closes |

## Verification
The hardest situation to reach from the ports is an opening condition that lands partway through a byte. Cutting a selector off after four bits leaves the bit counter and shift register half filled. The stimulus issues that cut, then sends a full store of a word address, then performs a current-location fetch. The fetch shows that the restart cleared the partial state and that the new address took effect. Pointer wrap needs a word address of 255 followed by two data bytes, and also a fetch that spans the top of memory. A fetch that the master refuses to acknowledge is followed by one more byte of clocks with the line released, which shows that the block has gone silent.

// File: rtl/tws_pkg.sv
package tws_pkg;

  localparam int BYTE_W   = 8;
  localparam int TYPE_W   = 4;
  localparam int STRAP_W  = 3;
  localparam int ACK_SLOT = 8;   // bit count once eight bits have been clocked
  localparam int END_SLOT = 9;   // bit count during the ninth clock

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_WADDR,
    ST_WDATA,
    ST_RDATA,
    ST_QUIET
  } tws_state_t;

  // selector layout: {type, strap, dir}
  function automatic logic sel_hit(input logic [BYTE_W-1:0] b,
                                   input logic [STRAP_W-1:0] strap,
                                   input logic [TYPE_W-1:0] type_id);
    return (b[BYTE_W-1 -: TYPE_W] == type_id) && (b[STRAP_W:1] == strap);
  endfunction

  function automatic logic sel_is_read(input logic [BYTE_W-1:0] b);
    return b[0];
  endfunction

endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic q_prev
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RESET_VAL;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[LAST-1:0], d};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_prev <= RESET_VAL;
    else        q_prev <= chain[LAST];
  end

  assign q = chain[LAST];
endmodule

// File: rtl/tws_bus_events.sv
module tws_bus_events (
  input  logic scl,
  input  logic scl_prev,
  input  logic sda,
  input  logic sda_prev,
  output logic open_evt,
  output logic close_evt,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_held;

  assign scl_held  = scl & scl_prev;
  assign open_evt  = scl_held & sda_prev & ~sda;
  assign close_evt = scl_held & ~sda_prev & sda;
  assign scl_rise  = scl & ~scl_prev;
  assign scl_fall  = ~scl & scl_prev;
endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
  import tws_pkg::*;
#(
  parameter int          AW       = 8,
  parameter logic [3:0]  DEV_TYPE = 4'b1010
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               open_evt,
  input  logic               close_evt,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               sda_s,
  input  logic [STRAP_W-1:0] strap,
  input  logic               wr_busy,
  input  logic [BYTE_W-1:0]  mem_rdata,
  output logic [AW-1:0]      ptr,
  output logic               drive_low,
  output logic               wb_valid,
  output logic [AW-1:0]      wb_addr,
  output logic [BYTE_W-1:0]  wb_data,
  output logic               wb_commit,
  output logic               sel_ack,
  output logic               in_idle
);
  localparam logic [3:0] ACK_C = 4'(ACK_SLOT);
  localparam logic [3:0] END_C = 4'(END_SLOT);
  localparam logic [3:0] LST_C = 4'(ACK_SLOT - 1);

  function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
    return p + {{(AW-1){1'b0}}, 1'b1};
  endfunction

  tws_state_t        state;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] shreg;
  logic              ack_pend;
  logic              rd_dir;
  logic              mack;
  logic              got_data;
  logic [BYTE_W-1:0] rx_next;
  logic              hit_now;
  logic              rx_state;

  assign rx_next  = {shreg[BYTE_W-2:0], sda_s};
  assign hit_now  = sel_hit(rx_next, strap, DEV_TYPE) && !wr_busy;
  assign rx_state = (state == ST_SEL) || (state == ST_WADDR) || (state == ST_WDATA);
  assign in_idle  = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      ack_pend  <= 1'b0;
      rd_dir    <= 1'b0;
      mack      <= 1'b0;
      got_data  <= 1'b0;
      ptr       <= '0;
      drive_low <= 1'b0;
      wb_valid  <= 1'b0;
      wb_addr   <= '0;
      wb_data   <= '0;
      wb_commit <= 1'b0;
      sel_ack   <= 1'b0;
    end else begin
      wb_valid  <= 1'b0;
      wb_commit <= 1'b0;
      sel_ack   <= 1'b0;
      if (open_evt) begin
        state     <= ST_SEL;
        cnt       <= '0;
        drive_low <= 1'b0;
        ack_pend  <= 1'b0;
        got_data  <= 1'b0;
      end else if (close_evt) begin
        if (state == ST_WDATA && got_data) wb_commit <= 1'b1;
        state     <= ST_IDLE;
        cnt       <= '0;
        drive_low <= 1'b0;
      end else if (rx_state) begin
        if (scl_rise && cnt < ACK_C) begin
          shreg <= rx_next;
          cnt   <= cnt + 4'd1;
          if (cnt == LST_C) begin
            unique case (state)
              ST_SEL: begin
                ack_pend <= hit_now;
                sel_ack  <= hit_now;
                rd_dir   <= sel_is_read(rx_next);
              end
              ST_WADDR: begin
                ptr      <= rx_next[AW-1:0];
                ack_pend <= 1'b1;
              end
              default: begin
                wb_valid <= 1'b1;
                wb_addr  <= ptr;
                wb_data  <= rx_next;
                ptr      <= ptr_step(ptr);
                got_data <= 1'b1;
                ack_pend <= 1'b1;
              end
            endcase
          end
        end else if (scl_fall && cnt == ACK_C) begin
          drive_low <= ack_pend;
          cnt       <= END_C;
        end else if (scl_fall && cnt == END_C) begin
          drive_low <= 1'b0;
          cnt       <= '0;
          if (!ack_pend) begin
            state <= ST_IDLE;
          end else if (state == ST_SEL) begin
            if (rd_dir) begin
              state     <= ST_RDATA;
              shreg     <= mem_rdata;
              drive_low <= ~mem_rdata[BYTE_W-1];
              ptr       <= ptr_step(ptr);
            end else begin
              state <= ST_WADDR;
            end
          end else if (state == ST_WADDR) begin
            state <= ST_WDATA;
          end
        end
      end else if (state == ST_RDATA) begin
        if (scl_rise) begin
          if (cnt < ACK_C)       cnt  <= cnt + 4'd1;
          else if (cnt == END_C) mack <= ~sda_s;
        end else if (scl_fall) begin
          if (cnt >= 4'd1 && cnt < ACK_C) begin
            shreg     <= {shreg[BYTE_W-2:0], shreg[BYTE_W-1]};
            drive_low <= ~shreg[BYTE_W-2];
          end else if (cnt == ACK_C) begin
            drive_low <= 1'b0;
            cnt       <= END_C;
          end else if (cnt == END_C) begin
            cnt <= '0;
            if (mack) begin
              shreg     <= mem_rdata;
              drive_low <= ~mem_rdata[BYTE_W-1];
              ptr       <= ptr_step(ptr);
            end else begin
              state <= ST_QUIET;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave #(
  parameter int         AW        = 8,
  parameter int         SYNC_STGS = 2,
  parameter logic [3:0] DEV_TYPE  = 4'b1010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_drive_low,
  input  logic [2:0]    strap_addr,
  input  logic          wr_busy,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata,
  output logic          wb_valid,
  output logic [AW-1:0] wb_addr,
  output logic [7:0]    wb_data,
  output logic          wb_commit
);
  // named internal events, also observed by the bound checker
  logic scl_s, scl_p, sda_s, sda_p;
  logic open_evt, close_evt, scl_rise, scl_fall;
  logic sel_ack, in_idle;

  tws_sync #(.STAGES(SYNC_STGS), .RESET_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s), .q_prev(scl_p)
  );

  tws_sync #(.STAGES(SYNC_STGS), .RESET_VAL(1'b1)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s), .q_prev(sda_p)
  );

  tws_bus_events u_events (
    .scl(scl_s), .scl_prev(scl_p), .sda(sda_s), .sda_prev(sda_p),
    .open_evt(open_evt), .close_evt(close_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  tws_ctrl #(.AW(AW), .DEV_TYPE(DEV_TYPE)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .open_evt(open_evt), .close_evt(close_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .strap(strap_addr), .wr_busy(wr_busy), .mem_rdata(mem_rdata),
    .ptr(mem_addr), .drive_low(sda_drive_low),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data),
    .wb_commit(wb_commit), .sel_ack(sel_ack), .in_idle(in_idle)
  );
endmodule

// File: rtl/tw_eeprom_slave_chk.sv
module tw_eeprom_slave_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          sda_drive_low,
  input logic          wr_busy,
  input logic          open_evt,
  input logic          close_evt,
  input logic          sel_ack,
  input logic          in_idle,
  input logic          wb_valid,
  input logic [AW-1:0] wb_addr,
  input logic [AW-1:0] mem_addr
);
  p_drive_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_low) |-> !scl_s);

  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_drive_low);

  p_busy_noack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ack |-> !$past(wr_busy));

  p_open_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    open_evt |=> (!sda_drive_low && !in_idle));

  p_close_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    close_evt |=> in_idle);

  p_wb_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid);

  p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (mem_addr == AW'(wb_addr + 1'b1)));
endmodule

bind tw_eeprom_slave tw_eeprom_slave_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_drive_low(sda_drive_low),
  .wr_busy(wr_busy), .open_evt(open_evt), .close_evt(close_evt),
  .sel_ack(sel_ack), .in_idle(in_idle), .wb_valid(wb_valid),
  .wb_addr(wb_addr), .mem_addr(mem_addr)
);

// File: tb/tw_eeprom_slave_bench.sv
`timescale 1ns/1ps
module tw_eeprom_slave_bench;
  localparam int Q = 100;           // quarter bus-clock period, ns
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] SEL_W = 8'hAA;  // 1010_101_0
  localparam logic [7:0] SEL_R = 8'hAB;  // 1010_101_1

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, m_low = 1'b0, busy = 1'b0;
  logic sda_drive_low, wb_valid, wb_commit;
  logic [7:0] mem_addr, wb_addr, wb_data, mem_rdata;
  wire sda_bus = ~(m_low | sda_drive_low);

  int total = 0, bad = 0, viol = 0, commits = 0, wb_n = 0;
  logic [7:0] log_a [16];
  logic [7:0] log_d [16];
  logic prev_drv = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 7) ^ 8'h3C);
  endfunction
  assign mem_rdata = pat(int'(mem_addr));

  tw_eeprom_slave u_tw_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus),
    .sda_drive_low(sda_drive_low), .strap_addr(STRAP), .wr_busy(busy),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .wb_valid(wb_valid),
    .wb_addr(wb_addr), .wb_data(wb_data), .wb_commit(wb_commit)
  );

  always @(negedge clk) begin
    if (wb_valid && wb_n < 16) begin
      log_a[wb_n] = wb_addr; log_d[wb_n] = wb_data; wb_n++;
    end
    if (wb_commit) commits++;
    if (rst_n && sda_drive_low != prev_drv && scl) viol++;
    prev_drv = sda_drive_low;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_open();
    m_low = 1'b0; #Q; scl = 1'b1; #Q; m_low = 1'b1; #Q; scl = 1'b0; #Q;
  endtask
  task automatic bus_close();
    m_low = 1'b1; #Q; scl = 1'b1; #Q; m_low = 1'b0; #Q; #Q;
  endtask
  task automatic put_bit(input logic b);
    scl = 1'b0; #Q; m_low = ~b; #Q; scl = 1'b1; #(2*Q); scl = 1'b0;
  endtask
  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    #Q; m_low = 1'b0; #Q; scl = 1'b1; #Q; ack = ~sda_bus; #Q; scl = 1'b0;
  endtask
  task automatic get_byte(input logic give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      #Q; m_low = 1'b0; #Q; scl = 1'b1; #Q; d[i] = sda_bus; #Q; scl = 1'b0;
    end
    #Q; m_low = give_ack; #Q; scl = 1'b1; #(2*Q); scl = 1'b0;
    #Q; m_low = 1'b0;
  endtask

  task automatic t_reset();
    check(sda_drive_low == 1'b0, "R1 reset release", sda_drive_low, 0);
    check(wb_valid == 1'b0 && wb_commit == 1'b0, "R4 reset strobes", wb_valid, 0);
  endtask

  task automatic t_no_open();
    logic a;
    put_byte(SEL_W, a);
    check(a == 1'b0, "R1 no ack before open", a, 0);
  endtask

  task automatic t_mismatch();
    logic a;
    bus_open(); put_byte(8'h6A, a);
    check(a == 1'b0, "R2 wrong type", a, 0);
    bus_close();
    bus_open(); put_byte(8'hA2, a);
    check(a == 1'b0, "R2 wrong strap", a, 0);
    bus_close();
  endtask

  task automatic t_byte_write();
    logic a0, a1, a2;
    int n0 = wb_n, c0 = commits;
    bus_open(); put_byte(SEL_W, a0); put_byte(8'h10, a1); put_byte(8'hA5, a2);
    bus_close();
    check(a0 == 1'b1, "R2 selector ack", a0, 1);
    check(a1 && a2, "R4 byte acks", {a1, a2}, 3);
    check(wb_n == n0 + 1 && log_a[n0] == 8'h10 && log_d[n0] == 8'hA5,
          "R4 handed byte", {log_a[n0], log_d[n0]}, 16'h10A5);
    check(commits == c0 + 1, "R7 commit pulse", commits - c0, 1);
  endtask

  task automatic t_busy();
    logic a;
    busy = 1'b1;
    bus_open(); put_byte(SEL_W, a); bus_close();
    busy = 1'b0;
    check(a == 1'b0, "R3 busy no ack", a, 0);
  endtask

  task automatic t_random_read();
    logic a;
    logic [7:0] d;
    bus_open(); put_byte(SEL_W, a); put_byte(8'h20, a);
    bus_open(); put_byte(SEL_R, a);
    check(a == 1'b1, "R6 read selector ack", a, 1);
    for (int k = 0; k < 3; k++) begin
      get_byte(k < 2, d);
      check(d == pat(8'h20 + k), "R6 read data", d, pat(8'h20 + k));
    end
    check(mem_addr == 8'h23, "R5 pointer after read", mem_addr, 8'h23);
    get_byte(1'b0, d);
    check(d == 8'hFF, "R6 silent after nack", d, 8'hFF);
    bus_close();
  endtask

  task automatic t_wrap();
    logic a;
    logic [7:0] d0, d1;
    int n0 = wb_n;
    bus_open(); put_byte(SEL_W, a); put_byte(8'hFF, a);
    put_byte(8'h11, a); put_byte(8'h22, a); bus_close();
    check(log_a[n0] == 8'hFF && log_a[n0+1] == 8'h00, "R5 write wrap",
          {log_a[n0], log_a[n0+1]}, 16'hFF00);
    check(mem_addr == 8'h01, "R5 pointer after wrap", mem_addr, 1);
    bus_open(); put_byte(SEL_W, a); put_byte(8'hFF, a);
    bus_open(); put_byte(SEL_R, a); get_byte(1'b1, d0); get_byte(1'b0, d1);
    bus_close();
    check(d0 == pat(255) && d1 == pat(0), "R5 read wrap", {d0, d1},
          {pat(255), pat(0)});
  endtask

  task automatic t_mid_open();
    logic a;
    logic [7:0] d;
    bus_open();
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_open(); put_byte(SEL_W, a);
    check(a == 1'b1, "R8 ack after restart", a, 1);
    put_byte(8'h40, a); bus_close();
    bus_open(); put_byte(SEL_R, a); get_byte(1'b0, d); bus_close();
    check(d == pat(8'h40), "R8 address after restart", d, pat(8'h40));
  endtask

  task automatic t_close_idle();
    logic a;
    put_byte(SEL_W, a);
    check(a == 1'b0, "R7 idle after close", a, 0);
    check(viol == 0, "R9 drive changes with clock low", viol, 0);
  endtask

  initial begin
    #3000 rst_n = 1'b1;
    #400;
    t_reset();
    t_no_open();
    bus_close();
    t_mismatch();
    t_byte_write();
    t_busy();
    t_random_read();
    t_wrap();
    t_mid_open();
    t_close_idle();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #3000000;
    if (!done) begin
      done = 1'b1; total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule